// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Port

This block holds a word of `WIDTH` stages, stage A being bit 0 and stage H being bit `WIDTH-1`. On each rising clock edge it either keeps its contents, moves every stage one place toward H, moves every stage one place toward A, or takes a whole new word in parallel. A two-bit mode input selects which of these happens. Each shift direction has its own serial input. Two serial outputs always show the two end stages, so several blocks can be chained into a longer register.

Parallel data enters and leaves through one shared port. Because a bidirectional pin cannot be synthesized inside a chip, the port is split into an input vector, an output vector and a per-bit drive-enable vector, and a pad ring combines them. The port drives the register contents only when both active-low output enables are low and the block is not loading. In load mode the drivers are always off, so an external source can use the port. An active-low asynchronous reset clears the register.

The data paths have no valid/ready handshake and no back-pressure. The block takes its inputs on every edge and cannot stall, so the mode pins act as the only qualifier. All pins are plain control or data pins.

Top module: `usr_bidir_shifter`

## Requirements
- R1: With mode = 2'b11 (parallel load), the register takes `port_in` on the rising clock edge. Every stage holds the value of the matching port bit after that edge.
- R2: While mode = 2'b11, `port_oe` is all zeros, even when both `oe_a_n` and `oe_b_n` are low.
- R3: With mode = 2'b01 (shift toward H), the edge puts `ser_in_right` into bit 0 and the old bit i-1 into bit i, for i = 1 to WIDTH-1.
- R4: With mode = 2'b10 (shift toward A), the edge puts `ser_in_left` into bit WIDTH-1 and the old bit i+1 into bit i, for i = 0 to WIDTH-2.
- R5: With mode = 2'b00 (hold), the register keeps its value across clock edges.
- R6: If `oe_a_n` or `oe_b_n` is high, `port_oe` is all zeros. Loading, shifting and reset still change the register normally in that state.
- R7: A low `rst_n` clears every stage at once, without waiting for a clock edge. While `rst_n` stays low the register stays zero, whatever the clock, the mode or the data inputs do.
- R8: `tap_first` always equals bit 0 and `tap_last` always equals bit WIDTH-1. Neither output depends on the enables or the mode.
- R9: When both output enables are low and the mode is not 2'b11, `port_oe` is all ones and `port_out` equals the register contents. After a clock edge the new contents appear on the port and both taps together.
- R10: `port_in` has no effect on the register in modes 2'b00, 2'b01 and 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous clear, active low |
| mode_sel | input | 2 | 00 hold, 01 shift toward H, 10 shift toward A, 11 parallel load |
| oe_a_n | input | 1 | First port output enable, active low |
| oe_b_n | input | 1 | Second port output enable, active low |
| ser_in_right | input | 1 | Serial data entering bit 0 on a shift toward H |
| ser_in_left | input | 1 | Serial data entering bit WIDTH-1 on a shift toward A |
| port_in | input | WIDTH | Shared port, value seen at the pins |
| port_out | output | WIDTH | Shared port, value driven when enabled |
| port_oe | output | WIDTH | Per-bit drive enable for the shared port |
| tap_first | output | 1 | Always-driven copy of bit 0 |
| tap_last | output | 1 | Always-driven copy of bit WIDTH-1 |

## Verification
The bench builds the block with the default `WIDTH` of 8. With that width, eight shifts carry a single serial bit from one end to the other and out through the opposite tap, and every stage can be reached in a short run. That width also lets random port words cover all patterns of a byte. The bench drives random port data during hold and shift steps to show that the data is ignored. It toggles each enable on its own, including during loads, and pulls reset low in the middle of a run while load mode and clock edges continue.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,
    MODE_SHL  = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_mode_decode.sv
module usr_mode_decode
  import usr_pkg::*;
(
  input  logic [1:0] mode_sel,
  output usr_mode_e  mode,
  output logic       is_load,
  output logic       is_shr,
  output logic       is_shl
);
  always_comb begin
    mode    = usr_mode_e'(mode_sel);
    is_load = 1'b0;
    is_shr  = 1'b0;
    is_shl  = 1'b0;
    unique case (mode)
      MODE_LOAD: is_load = 1'b1;
      MODE_SHR:  is_shr  = 1'b1;
      MODE_SHL:  is_shl  = 1'b1;
      default:   ;
    endcase
  end
endmodule

// File: rtl/usr_stage_array.sv
module usr_stage_array #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_load,
  input  logic             is_shr,
  input  logic             is_shl,
  input  logic             ser_r,
  input  logic             ser_l,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] nxt;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic from_low;
    logic from_high;
    if (i == 0) begin : g_low_end
      assign from_low = ser_r;
    end else begin : g_low_mid
      assign from_low = q[i-1];
    end
    if (i == MSB) begin : g_high_end
      assign from_high = ser_l;
    end else begin : g_high_mid
      assign from_high = q[i+1];
    end
    always_comb begin
      if (is_load)     nxt[i] = par_in[i];
      else if (is_shr) nxt[i] = from_low;
      else if (is_shl) nxt[i] = from_high;
      else             nxt[i] = q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  // R1 load capture
  a_r1_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
    is_load |=> q == $past(par_in));
  // R3 shift toward H
  a_r3_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
    is_shr |=> (q[0] == $past(ser_r)) && (q[MSB:1] == $past(q[MSB-1:0])));
  // R4 shift toward A
  a_r4_shift_down: assert property (@(posedge clk) disable iff (!rst_n)
    is_shl |=> (q[MSB] == $past(ser_l)) && (q[MSB-1:0] == $past(q[MSB:1])));
  // R5 hold
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_load && !is_shr && !is_shl) |=> $stable(q));
  // R7 reset keeps register clear
  a_r7_reset_clear: assert property (@(posedge clk)
    !rst_n |-> q == '0);
endmodule

// File: rtl/usr_port_drive.sv
module usr_port_drive #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] q,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic             is_load,
  output logic [WIDTH-1:0] port_out,
  output logic [WIDTH-1:0] port_oe
);
  logic drive_en;
  assign drive_en = !oe_a_n && !oe_b_n && !is_load;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pad
    assign port_out[i] = q[i];
    assign port_oe[i]  = drive_en;
  end

  // R6 either enable high turns the port off
  always_comb begin
    if (oe_a_n || oe_b_n)
      a_r6_port_off: assert (port_oe == '0);
  end
endmodule

// File: rtl/usr_bidir_shifter.sv
module usr_bidir_shifter
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic             ser_in_right,
  input  logic             ser_in_left,
  input  logic [WIDTH-1:0] port_in,
  output logic [WIDTH-1:0] port_out,
  output logic [WIDTH-1:0] port_oe,
  output logic             tap_first,
  output logic             tap_last
);
  localparam int MSB = WIDTH - 1;

  usr_mode_e        mode;
  logic             is_load, is_shr, is_shl;
  logic [WIDTH-1:0] q;

  usr_mode_decode u_dec (
    .mode_sel (mode_sel),
    .mode     (mode),
    .is_load  (is_load),
    .is_shr   (is_shr),
    .is_shl   (is_shl)
  );

  usr_stage_array #(.WIDTH(WIDTH)) u_stages (
    .clk     (clk),
    .rst_n   (rst_n),
    .is_load (is_load),
    .is_shr  (is_shr),
    .is_shl  (is_shl),
    .ser_r   (ser_in_right),
    .ser_l   (ser_in_left),
    .par_in  (port_in),
    .q       (q)
  );

  usr_port_drive #(.WIDTH(WIDTH)) u_port (
    .q        (q),
    .oe_a_n   (oe_a_n),
    .oe_b_n   (oe_b_n),
    .is_load  (is_load),
    .port_out (port_out),
    .port_oe  (port_oe)
  );

  assign tap_first = q[0];
  assign tap_last  = q[MSB];

  // R2 load mode keeps the port off whatever the enables
  a_r2_load_port_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b11) |-> (port_oe == '0));
  // R9 enabled port shows the taps' stages
  a_r9_port_matches_taps: assert property (@(posedge clk) disable iff (!rst_n)
    (port_oe[0] == 1'b1) |-> (port_out[0] == tap_first) && (port_out[MSB] == tap_last));
  // R10 port word is ignored outside load mode
  a_r10_port_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00) |=> $stable(tap_first) && $stable(tap_last));
endmodule

// File: tb/sim_usr_bidir_shifter.sv
`timescale 1ns/1ps
module sim_usr_bidir_shifter;
  localparam int W = 8;

  typedef struct {
    logic [W-1:0] q;
    logic         en;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic oe_a_n = 1'b0, oe_b_n = 1'b0;
  logic ser_in_right = 1'b0, ser_in_left = 1'b0;
  logic [W-1:0] port_in = '0;
  logic [W-1:0] port_out, port_oe;
  logic tap_first, tap_last;

  int checks = 0, failures = 0;
  logic [W-1:0] model = '0;
  exp_t sb[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  usr_bidir_shifter #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .ser_in_right(ser_in_right), .ser_in_left(ser_in_left), .port_in(port_in),
    .port_out(port_out), .port_oe(port_oe), .tap_first(tap_first), .tap_last(tap_last)
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: apply one step at the falling edge and queue the expected result
  task automatic step(input logic [1:0] m, input logic ea, input logic eb,
                      input logic sr, input logic sl, input logic [W-1:0] pin, input string tag);
    exp_t e;
    @(negedge clk);
    mode_sel = m; oe_a_n = ea; oe_b_n = eb;
    ser_in_right = sr; ser_in_left = sl; port_in = pin;
    case (m)
      2'b11: model = pin;
      2'b01: model = {model[W-2:0], sr};
      2'b10: model = {sl, model[W-1:1]};
      default: ;
    endcase
    e.q = model;
    e.en = !ea && !eb && (m != 2'b11);
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() != 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(port_oe == {W{e.en}}, {e.tag, " R2/R6/R9 port_oe"}, port_oe, {W{e.en}});
        if (e.en) chk(port_out == e.q, {e.tag, " R9 port_out"}, port_out, e.q);
        chk({tap_last, tap_first} == {e.q[W-1], e.q[0]}, {e.tag, " R8 taps"},
            W'({tap_last, tap_first}), W'({e.q[W-1], e.q[0]}));
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        chk(1'b0, "watchdog", '0, '0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    #20;
    chk(port_out == '0 && port_oe == '1, "R7 reset state", port_out, '0);
    chk(tap_first == 1'b0 && tap_last == 1'b0, "R7 reset taps", W'({tap_last, tap_first}), '0);
    @(negedge clk); rst_n = 1'b1; model = '0;

    // R1 loads under various patterns, then R9 readback in hold
    step(2'b11, 1'b0, 1'b0, 0, 0, 8'hA5, "R1 load a5");
    step(2'b00, 1'b0, 1'b0, 0, 0, 8'h00, "R5 hold");
    step(2'b11, 1'b0, 1'b0, 0, 0, 8'h3C, "R1 load 3c");
    step(2'b00, 1'b0, 1'b0, 1, 1, 8'hFF, "R10 hold ignores port");
    // R3 walk a one toward H and out through tap_last
    step(2'b11, 1'b0, 1'b0, 0, 0, 8'h00, "R1 load zero");
    step(2'b01, 1'b0, 1'b0, 1, 0, 8'hFF, "R3 shift in one");
    for (int i = 0; i < W - 1; i++) step(2'b01, 1'b0, 1'b0, 0, 1, 8'h55, "R3 walk up");
    // R4 walk back toward A
    for (int i = 0; i < W - 1; i++) step(2'b10, 1'b0, 1'b0, 0, 0, 8'hAA, "R4 walk down");
    step(2'b10, 1'b0, 1'b0, 0, 1, 8'h0F, "R4 shift in one");
    // R6: each enable high alone, register keeps working
    step(2'b11, 1'b1, 1'b0, 0, 0, 8'hC3, "R6 load with oe_a high");
    step(2'b01, 1'b0, 1'b1, 1, 0, 8'h00, "R6 shift with oe_b high");
    step(2'b10, 1'b1, 1'b1, 0, 1, 8'h99, "R6 shift with both high");
    step(2'b00, 1'b0, 1'b0, 0, 0, 8'h77, "R6 readback");
    // R2 load with both enables low
    step(2'b11, 1'b0, 1'b0, 0, 0, 8'h81, "R2 load port off");
    // random mix, port data random in every mode (R10)
    for (int i = 0; i < 200; i++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      step(m, 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0),
           1'($urandom), 1'($urandom), W'($urandom), "R10 random mix");
    end
    step(2'b00, 1'b0, 1'b0, 0, 0, 8'hFF, "R5 settle");
    @(negedge clk);
    @(negedge clk);

    // R7 reset mid-run: clears at once, load and clocks ignored while low
    step(2'b11, 1'b0, 1'b0, 0, 0, 8'hFF, "R1 load ff");
    @(negedge clk);
    mode_sel = 2'b00;
    #1;
    chk(port_out == 8'hFF, "R9 before reset", port_out, 8'hFF);
    rst_n = 1'b0;
    #1;
    chk(port_out == '0 && tap_first == 1'b0 && tap_last == 1'b0, "R7 async clear", port_out, '0);
    mode_sel = 2'b11; port_in = 8'hFF; ser_in_right = 1'b1;
    @(posedge clk); #2;
    mode_sel = 2'b00;
    #1;
    chk(port_out == '0 && tap_last == 1'b0, "R7 overrides load", port_out, '0);
    @(negedge clk); rst_n = 1'b1; model = '0;
    step(2'b01, 1'b0, 1'b0, 1, 0, 8'hFF, "R3 after reset");
    step(2'b00, 1'b0, 1'b0, 0, 0, 8'h00, "R5 after reset");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule